// File: doc/BRIEF.md
# Delta-Sigma Bitstream Calibration Controller

This block sits on the host side of an external 1-bit second-order delta-sigma modulator. It samples the modulator bitstream on the falling edge of the modulator clock and counts ones over fixed windows. It also drives the two configuration lines of the modulator. One line selects normal conversion or calibration. The other selects which calibration is active: offset, with the inputs tied to ground, or gain, with the inputs tied to the reference.

After reset, and again on each start request, the block runs a self-calibration. It first measures an offset count and then a gain count. After each configuration change it discards a programmable number of settling windows. If the gain count exceeds the offset count, both counts are stored. Otherwise an error flag is raised and the earlier pair is kept. The block then returns to normal sampling. Each normal window yields a calibrated code equal to the full-scale value times (ones − offset) divided by (gain − offset), clamped to the range from 0 to full scale.

Results leave through a valid/ready port. A result stays on the port until it is accepted. A window that finishes its division while the port still holds an unaccepted result is dropped. A start request that arrives during calibration, or during the select hold time, is queued and served afterwards. A window length below the minimum needed by the divider is raised to that minimum.

Top module: `ds_cal_ctrl`

## Requirements
- R1: During reset, `mod_run` is high, `mod_gsel` is low, `res_valid` is low and `cal_err` is low.
- R2: `mod_bit` is sampled on the falling edge of `clk`. A value present only between a falling edge and the next rising edge is never counted.
- R3: When reset is released, a calibration starts without any request. It runs in three steps: offset configuration (`mod_run`=0, `mod_gsel`=0), then gain configuration (`mod_run`=0, `mod_gsel`=1), then normal operation (`mod_run`=1).
- R4: After `mod_run` rises, `mod_gsel` stays unchanged for exactly SEL_HOLD clock cycles. It then returns to 0. `mod_gsel` never changes within SEL_HOLD cycles after a rise of `mod_run`.
- R5: Each calibration step discards `settle_win` whole windows and captures the next one. The offset step therefore lasts (settle_win+1)·L+2 cycles, and so does the gain step, where L is the window length.
- R6: In normal operation, each window count n yields `res_data` = floor(FULL·(n−off)/(gain−off)), where FULL = 2^RES_W−1. The result is 0 when n ≤ off and FULL when n ≥ gain. The first settle_win windows after calibration yield no result.
- R7: A calibration whose gain count is not greater than its offset count sets `cal_err` to 1. The previous offset and gain counts stay in use.
- R8: A calibration with gain count greater than offset count clears `cal_err` and uses the new counts from then on.
- R9: A one-cycle pulse on `cal_start` during normal operation, once the select hold has elapsed, drops `mod_run` on the next clock edge and reruns the full calibration.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` stays stable.
- R11: No new result appears on the output port while `mod_run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator bitstream |
| cal_start | input | 1 | Calibration request pulse |
| win_len | input | WIN_W | Window length in clock cycles, taken at each window start |
| settle_win | input | SETTLE_W | Windows discarded after each configuration change |
| mod_run | output | 1 | High: normal conversion; low: calibration |
| mod_gsel | output | 1 | Calibration select: 1 gain, 0 offset |
| res_data | output | RES_W | Calibrated result |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted when high together with valid |
| cal_err | output | 1 | Last calibration failed (gain not above offset) |

## Verification
The bench stands in for the modulator. Its ones density depends on the configuration lines: half the samples are ones during offset calibration and nine in ten during gain calibration. In normal operation it plays periodic patterns whose period divides the window length, so every window holds a known count whatever its alignment. Inputs at zero, at the offset level, just above it, at the gain level and at full ones separate the two clamps from the scaling path. Random densities exercise the division itself. Between falling and rising edges the bench drives the inverted bit, which exposes any rising-edge sampling. A failing gain pattern followed by a good one with different levels shows whether the old counts are kept and whether the new ones take over.

// File: rtl/ds_cal_pkg.sv
package ds_cal_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_OFF  = 2'd1,
    PH_GAIN = 2'd2
  } cal_phase_e;
endpackage

// File: rtl/ds_win_count.sv
// Counts ones over back-to-back windows; restart aligns a fresh window.
module ds_win_count #(
  parameter int WIN_W   = 10,
  parameter int MIN_WIN = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             bit_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             done_o,
  output logic [WIN_W-1:0] ones_o
);
  logic [WIN_W-1:0] pos_q, acc_q, len_q, len_eff, acc_nx;

  always_comb begin
    len_eff = (len_i < WIN_W'(MIN_WIN)) ? WIN_W'(MIN_WIN) : len_i;
    acc_nx  = acc_q + WIN_W'(bit_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      acc_q  <= '0;
      len_q  <= WIN_W'(MIN_WIN);
      done_o <= 1'b0;
      ones_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (restart_i) begin
        pos_q <= '0;
        acc_q <= '0;
        len_q <= len_eff;
      end else if (pos_q == len_q - WIN_W'(1)) begin
        done_o <= 1'b1;
        ones_o <= acc_nx;
        pos_q  <= '0;
        acc_q  <= '0;
        len_q  <= len_eff;
      end else begin
        pos_q <= pos_q + WIN_W'(1);
        acc_q <= acc_nx;
      end
    end
  end
endmodule

// File: rtl/ds_cal_seq.sv
// Calibration sequencer: drives configuration lines, captures counts.
module ds_cal_seq
  import ds_cal_pkg::*;
#(
  parameter int WIN_W    = 10,
  parameter int SETTLE_W = 3,
  parameter int SEL_HOLD = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                win_done_i,
  input  logic [WIN_W-1:0]    win_ones_i,
  output logic                restart_o,
  output logic                run_o,
  output logic                gsel_o,
  output logic                conv_go_o,
  output logic [WIN_W-1:0]    conv_ones_o,
  output logic [WIN_W-1:0]    off_o,
  output logic [WIN_W-1:0]    gain_o,
  output logic                err_o
);
  localparam int HOLD_W = $clog2(SEL_HOLD + 1);

  cal_phase_e          phase_q;
  logic [SETTLE_W-1:0] skip_q;
  logic [HOLD_W-1:0]   hold_q;
  logic                pend_q;
  logic [WIN_W-1:0]    off_tmp_q;
  logic                take_win;

  // A window is usable once settling is over and no restart is in flight.
  always_comb take_win = win_done_i && !restart_o && (skip_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_RUN;
      skip_q      <= '0;
      hold_q      <= '0;
      pend_q      <= 1'b1;
      off_tmp_q   <= '0;
      restart_o   <= 1'b0;
      run_o       <= 1'b1;
      gsel_o      <= 1'b0;
      conv_go_o   <= 1'b0;
      conv_ones_o <= '0;
      off_o       <= '0;
      gain_o      <= '1;
      err_o       <= 1'b0;
    end else begin
      restart_o <= 1'b0;
      conv_go_o <= 1'b0;
      if (start_i) pend_q <= 1'b1;
      if (hold_q != '0) begin
        hold_q <= hold_q - HOLD_W'(1);
        if (hold_q == HOLD_W'(1)) gsel_o <= 1'b0;
      end
      if (win_done_i && !restart_o && skip_q != '0) skip_q <= skip_q - SETTLE_W'(1);
      unique case (phase_q)
        PH_RUN: begin
          if ((pend_q || start_i) && hold_q == '0) begin
            phase_q   <= PH_OFF;
            run_o     <= 1'b0;
            gsel_o    <= 1'b0;
            restart_o <= 1'b1;
            skip_q    <= settle_i;
            pend_q    <= 1'b0;
          end else if (take_win) begin
            conv_go_o   <= 1'b1;
            conv_ones_o <= win_ones_i;
          end
        end
        PH_OFF: begin
          if (take_win) begin
            off_tmp_q <= win_ones_i;
            phase_q   <= PH_GAIN;
            gsel_o    <= 1'b1;
            restart_o <= 1'b1;
            skip_q    <= settle_i;
          end
        end
        PH_GAIN: begin
          if (take_win) begin
            if (win_ones_i > off_tmp_q) begin
              off_o  <= off_tmp_q;
              gain_o <= win_ones_i;
              err_o  <= 1'b0;
            end else begin
              err_o  <= 1'b1;
            end
            phase_q   <= PH_RUN;
            run_o     <= 1'b1;
            hold_q    <= HOLD_W'(SEL_HOLD);
            restart_o <= 1'b1;
            skip_q    <= settle_i;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/ds_ratio_div.sv
// Clamped scale-and-divide, one quotient bit per cycle.
module ds_ratio_div #(
  parameter int WIN_W = 10,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [WIN_W-1:0] n_i,
  input  logic [WIN_W-1:0] off_i,
  input  logic [WIN_W-1:0] gain_i,
  output logic             done_o,
  output logic [RES_W-1:0] q_o
);
  localparam int NUM_W  = WIN_W + RES_W;
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int FULL   = (1 << RES_W) - 1;

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [NUM_W-1:0]  num_q, num_nx, prod;
  logic [WIN_W:0]    rem_q, rem_sh, rem_nx, den_q;
  logic              fits;

  always_comb begin
    prod   = NUM_W'(FULL) * NUM_W'(n_i - off_i);
    rem_sh = {rem_q[WIN_W-1:0], num_q[NUM_W-1]};
    fits   = (rem_sh >= den_q);
    rem_nx = fits ? (rem_sh - den_q) : rem_sh;
    num_nx = {num_q[NUM_W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      done_o <= 1'b0;
      q_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        if (n_i <= off_i) begin
          q_o    <= '0;
          done_o <= 1'b1;
        end else if (n_i >= gain_i) begin
          q_o    <= RES_W'(FULL);
          done_o <= 1'b1;
        end else begin
          num_q  <= prod;
          den_q  <= {1'b0, gain_i - off_i};
          rem_q  <= '0;
          step_q <= STEP_W'(NUM_W);
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        num_q  <= num_nx;
        rem_q  <= rem_nx;
        step_q <= step_q - STEP_W'(1);
        if (step_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          q_o    <= num_nx[RES_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/ds_cal_ctrl.sv
module ds_cal_ctrl #(
  parameter int WIN_W    = 10,
  parameter int RES_W    = 12,
  parameter int SETTLE_W = 3,
  parameter int SEL_HOLD = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mod_bit,
  input  logic                cal_start,
  input  logic [WIN_W-1:0]    win_len,
  input  logic [SETTLE_W-1:0] settle_win,
  output logic                mod_run,
  output logic                mod_gsel,
  output logic [RES_W-1:0]    res_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic                cal_err
);
  localparam int NUM_W   = WIN_W + RES_W;
  localparam int MIN_WIN = NUM_W + 4;

  logic             smp_q;
  logic             restart, win_done, conv_go, q_done;
  logic [WIN_W-1:0] win_ones, conv_ones, off_cnt, gain_cnt;
  logic [RES_W-1:0] q_val;

  // Bitstream captured on the falling edge of the modulator clock.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b0;
    else        smp_q <= mod_bit;
  end

  ds_win_count #(.WIN_W(WIN_W), .MIN_WIN(MIN_WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .bit_i(smp_q),
    .len_i(win_len), .done_o(win_done), .ones_o(win_ones)
  );

  ds_cal_seq #(.WIN_W(WIN_W), .SETTLE_W(SETTLE_W), .SEL_HOLD(SEL_HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(cal_start), .settle_i(settle_win),
    .win_done_i(win_done), .win_ones_i(win_ones), .restart_o(restart),
    .run_o(mod_run), .gsel_o(mod_gsel), .conv_go_o(conv_go),
    .conv_ones_o(conv_ones), .off_o(off_cnt), .gain_o(gain_cnt), .err_o(cal_err)
  );

  ds_ratio_div #(.WIN_W(WIN_W), .RES_W(RES_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go_i(conv_go), .n_i(conv_ones),
    .off_i(off_cnt), .gain_i(gain_cnt), .done_o(q_done), .q_o(q_val)
  );

  // Single output slot; results finishing while it is occupied are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (q_done && mod_run && (!res_valid || res_ready)) begin
        res_data  <= q_val;
        res_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ds_cal_ctrl_chk.sv
module ds_cal_ctrl_chk #(
  parameter int RES_W    = 12,
  parameter int SEL_HOLD = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_run,
  input logic             mod_gsel,
  input logic [RES_W-1:0] res_data,
  input logic             res_valid,
  input logic             res_ready,
  input logic             cal_err
);
  logic        run_d;
  logic [15:0] since_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d      <= 1'b1;
      since_rise <= 16'(SEL_HOLD);
    end else begin
      run_d <= mod_run;
      if (mod_run && !run_d)                 since_rise <= 16'd1;
      else if (since_rise < 16'(SEL_HOLD))   since_rise <= since_rise + 16'd1;
    end
  end

  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_run && $past(mod_run) && (mod_gsel != $past(mod_gsel))) |-> (since_rise >= 16'(SEL_HOLD)));

  p_offset_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_run) |-> !mod_gsel);

  p_gain_in_cal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_gsel) |-> !mod_run);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_no_result_in_cal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(mod_run));

  p_err_at_cal_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_err) |-> $rose(mod_run));
endmodule

bind ds_cal_ctrl ds_cal_ctrl_chk #(.RES_W(RES_W), .SEL_HOLD(SEL_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_run(mod_run), .mod_gsel(mod_gsel),
  .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready), .cal_err(cal_err)
);

// File: tb/ds_cal_ctrl_tb.sv
module ds_cal_ctrl_tb;
  localparam int WIN_W = 10, RES_W = 12, SETTLE_W = 3, SEL_HOLD = 25;
  localparam int L = 90;
  localparam int FULL = (1 << RES_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, mod_bit = 1'b0, cal_start = 1'b0, res_ready = 1'b0;
  logic [WIN_W-1:0] win_len = WIN_W'(L);
  logic [SETTLE_W-1:0] settle_win = SETTLE_W'(1);
  logic mod_run, mod_gsel, res_valid, cal_err;
  logic [RES_W-1:0] res_data;

  int ntest = 0, nfail = 0;
  int ko = 1, po = 2, kg = 9, pg = 10, ki = 1, pi = 2;
  int eoff = 45, egain = 81, exp_q = 0;
  int got = 0, stab_seen = 0, stab_bad = 0, cal_new_bad = 0;
  bit chk_en = 0, rdy_hold = 0;
  int unsigned idx = 0;
  int divs [12] = '{1, 2, 3, 5, 6, 9, 10, 15, 18, 30, 45, 90};

  always #5 clk = ~clk;

  ds_cal_ctrl #(.WIN_W(WIN_W), .RES_W(RES_W), .SETTLE_W(SETTLE_W), .SEL_HOLD(SEL_HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .cal_start(cal_start),
    .win_len(win_len), .settle_win(settle_win), .mod_run(mod_run), .mod_gsel(mod_gsel),
    .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready), .cal_err(cal_err)
  );

  function automatic int exp_res(int n, int o, int g);
    if (n <= o) return 0;
    if (n >= g) return FULL;
    return (FULL * (n - o)) / (g - o);
  endfunction

  task automatic check(string req, int act, int expv);
    ntest++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); #3;
  endtask

  // Modulator model; the bit is inverted after each falling edge (R2).
  initial begin
    forever begin
      @(posedge clk); #1;
      idx++;
      if (rst_n && !mod_run) begin
        if (mod_gsel) mod_bit = (int'(idx % pg) < kg);
        else          mod_bit = (int'(idx % po) < ko);
      end else begin
        mod_bit = (int'(idx % pi) < ki);
      end
      @(negedge clk); #1;
      mod_bit = ~mod_bit;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    forever begin
      @(posedge clk); #1;
      res_ready = rdy_hold ? 1'b0 : ($urandom % 4 != 0);
    end
  end

  // Output monitor.
  initial begin
    bit pv = 0, pr = 0, prun = 1;
    logic [RES_W-1:0] pd = '0;
    forever begin
      step();
      if (rst_n) begin
        if (pv && !pr) begin
          stab_seen++;
          if (!(res_valid && res_data == pd)) stab_bad++;
        end
        if (res_valid && !pv && !prun) cal_new_bad++;
        if (res_valid && res_ready && chk_en) begin
          got++;
          check("R6 result", int'(res_data), exp_q);
        end
      end
      pv = res_valid; pr = res_ready; pd = res_data; prun = mod_run;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    ntest++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  // Follows one calibration: R3 order, R5 durations, R4 hold, R11.
  task automatic watch_cal(int s, int max_wait);
    int c = 0;
    int bad0 = cal_new_bad;
    while (mod_run) begin step(); c++; end
    if (max_wait >= 0) check("R9 start latency", int'(c <= max_wait), 1);
    check("R3 offset step first", int'(mod_gsel), 0);
    c = 0;
    while (!mod_gsel) begin step(); c++; end
    check("R5 offset step length", c, (s + 1) * L + 2);
    check("R3 still calibrating in gain step", int'(mod_run), 0);
    c = 0;
    while (!mod_run) begin step(); c++; end
    check("R5 gain step length", c, (s + 1) * L + 2);
    check("R3 gain select at return to normal", int'(mod_gsel), 1);
    c = 0;
    while (mod_gsel) begin step(); c++; end
    check("R4 select hold", c, SEL_HOLD);
    check("R11 no result during calibration", cal_new_bad - bad0, 0);
  endtask

  task automatic run_phase(string req, int k, int p);
    ki = k; pi = p;
    chk_en = 0;
    repeat ((int'(settle_win) + 3) * L) step();
    exp_q = exp_res(L * k / p, eoff, egain);
    got = 0;
    chk_en = 1;
    repeat (5 * L) step();
    chk_en = 0;
    check({req, " results delivered"}, int'(got > 0), 1);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; cal_start = 1'b1;
    @(posedge clk); #1; cal_start = 1'b0;
  endtask

  initial begin
    repeat (4) step();
    check("R1 run line in reset", int'(mod_run), 1);
    check("R1 select line in reset", int'(mod_gsel), 0);
    check("R1 valid in reset", int'(res_valid), 0);
    check("R1 error flag in reset", int'(cal_err), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    watch_cal(1, -1);
    check("R3 calibration passed", int'(cal_err), 0);

    // Directed corners (R2 sampling on falling edge underlies every count).
    run_phase("R2 half density", 1, 2);
    run_phase("R6 zero ones clamp", 0, 1);
    run_phase("R6 just above offset", 23, 45);
    check("R6 just-above-offset expected", exp_res(46, 45, 81), 113);
    run_phase("R6 at gain level", 9, 10);
    run_phase("R6 all ones clamp", 1, 1);
    run_phase("R6 two thirds", 2, 3);
    for (int i = 0; i < 6; i++) begin
      int p = divs[$urandom % 12];
      run_phase("R6 random density", int'($urandom % (p + 1)), p);
    end

    // Back-pressure (R10).
    ki = 2; pi = 3;
    repeat (3 * L) step();
    rdy_hold = 1;
    repeat (4 * L) step();
    rdy_hold = 0;
    repeat (L) step();
    check("R10 back-pressure observed", int'(stab_seen > 2 * L), 1);
    check("R10 data held while not ready", stab_bad, 0);

    // Failing calibration keeps old counts (R7).
    kg = 3; pg = 10;
    settle_win = SETTLE_W'(2);
    pulse_start();
    watch_cal(2, 3);
    check("R7 error flag set", int'(cal_err), 1);
    run_phase("R7 old counts kept", 2, 3);

    // Good calibration with new levels (R8).
    ko = 1; po = 3; kg = 5; pg = 6;
    settle_win = SETTLE_W'(0);
    pulse_start();
    watch_cal(0, 3);
    check("R8 error flag cleared", int'(cal_err), 0);
    eoff = 30; egain = 75;
    run_phase("R8 new counts used", 1, 2);
    check("R8 expected value", exp_res(45, 30, 75), 1365);
    for (int i = 0; i < 3; i++) begin
      int p = divs[$urandom % 12];
      run_phase("R8 random density", int'($urandom % (p + 1)), p);
    end
    check("R10 final stability", stab_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule